// File: doc/BRIEF.md
# Serial Line Power Manager

This block is the digital control core that decides when a serial line interface may sleep. It takes one "level valid" flag per receiver. These flags come from an analog level detector and arrive asynchronously. It produces four outputs: an active-high line-activity status, an enable for the on-chip supply pump, an enable for the line drivers, and an enable for the receiver outputs. The analog detectors, the pump and the drivers lie outside the block. Here they appear only as enables.

Two host pins override the automatic behaviour:

- A low level on the active-low shutdown pin always powers the interface down.
- A high level on the keep-awake pin holds it up.

With neither override in force, the supply follows the activity status. That status uses two windows of different length. It drops only after a long window in which every receiver is idle. It rises after a short window of activity on any receiver.

Waking is staged. The pump turns on first, and the drivers are enabled only after a ramp delay. An optional hold-off keeps the interface up for a fixed time after the shutdown pin is released. This gives a slow peripheral time to drive valid levels. Every interval is given in microseconds and converted to clock cycles from the clock frequency parameter. The shutdown and keep-awake pins are taken to be synchronous to the clock.

Top module: `line_pwr_mgr`

## Requirements
- R1: `line_active` falls only after no receiver flag has been valid for IDLE_CYC consecutive synchronised samples (IDLE_US converted at CLK_HZ). Including the two-flop synchroniser, the output changes on the (IDLE_CYC+2)th rising edge after the last flag drops.
- R2: `line_active` rises after any one flag has been valid for ACT_CYC consecutive synchronised samples. The output changes on the (ACT_CYC+2)th rising edge after the flag is raised.
- R3: While `line_active` is low, a burst of activity shorter than ACT_CYC samples leaves it low. While `line_active` is high, any valid sample restarts the idle count from zero.
- R4: While `shut_n` is low, `supply_en` and `drv_en` are low from the next clock edge on, whatever `wake_force` and the line activity are doing.
- R5: With `shut_n` and `wake_force` both high, `supply_en` is high from the next edge on, even with every receiver idle.
- R6: With `shut_n` high, `wake_force` low and no hold-off running, `supply_en` follows `line_active` one edge later: it powers up when the status rises and down when it falls.
- R7: On wake-up, `supply_en` rises first and `drv_en` rises RAMP_CYC edges later. `drv_en` is never high while `supply_en` is low.
- R8: `rcv_out_en` equals the inverse of `rcv_en_n` in every power state. Powering down never changes it.
- R9: When `shut_n` rises with USE_HOLDOFF set, the supply stays up from the next edge until HOLD_CYC further edges have passed, even with all lines idle. It drops on the (HOLD_CYC+2)th edge after the pin rises.
- R10: After reset, `line_active`, `supply_en` and `drv_en` are low, and all interval counters are cleared.
- R11: The activity status keeps being evaluated while the interface is forced down or forced up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_ok_async | input | N_RX | Per-receiver valid-level flags, asynchronous |
| shut_n | input | 1 | Active-low manual shutdown; overrides everything |
| wake_force | input | 1 | Keep-awake; disables automatic shutdown |
| rcv_en_n | input | 1 | Active-low receiver output enable |
| line_active | output | 1 | High while a valid level is seen on some receiver |
| supply_en | output | 1 | Supply pump enable |
| drv_en | output | 1 | Line driver output enable |
| rcv_out_en | output | 1 | Receiver output enable |

## Verification
The bench builds the block with CLK_HZ of 2 MHz, three receivers and HOLD_US of 50. With these values the activity window is two cycles, the idle window 60, the ramp 200 and the hold-off 100. The two-cycle activity window allows testing a pulse one sample short of qualifying against one that exactly qualifies. The short windows let the bench sweep all seven non-empty receiver patterns through full wake and sleep cycles. For every transition it measures the edge count and compares it with the count derived from the microsecond parameters.

// File: rtl/line_pwr_pkg.sv
package line_pwr_pkg;

  typedef enum logic [1:0] {
    PW_OFF  = 2'd0,
    PW_RAMP = 2'd1,
    PW_ON   = 2'd2
  } pw_state_e;

  // Interval in microseconds to clock cycles, never less than one.
  function automatic int unsigned us_to_cyc(input longint unsigned us,
                                            input longint unsigned hz);
    longint unsigned c;
    c = (us * hz) / 64'd1000000;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/lpm_line_detect.sv
module lpm_line_detect #(
  parameter int          N_RX     = 2,
  parameter int unsigned IDLE_CYC = 60,
  parameter int unsigned ACT_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_RX-1:0] lvl_ok,
  output logic            line_active
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int AW = $clog2(ACT_CYC + 1);
  localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_CYC - 1);
  localparam logic [AW-1:0] ACT_LIM  = AW'(ACT_CYC - 1);

  logic          any_ok;
  logic [IW-1:0] idle_cnt;
  logic [AW-1:0] act_cnt;
  logic          idle_done;   // idle window complete this cycle
  logic          act_done;    // activity window complete this cycle

  assign any_ok    = |lvl_ok;
  assign idle_done = !any_ok && line_active && (idle_cnt == IDLE_LIM);
  assign act_done  = any_ok && !line_active && (act_cnt == ACT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_active <= 1'b0;
      idle_cnt    <= '0;
      act_cnt     <= '0;
    end else if (any_ok) begin
      idle_cnt <= '0;
      if (act_done) begin
        line_active <= 1'b1;
        act_cnt     <= '0;
      end else if (!line_active) begin
        act_cnt <= act_cnt + 1'b1;
      end
    end else begin
      act_cnt <= '0;
      if (idle_done) begin
        line_active <= 1'b0;
        idle_cnt    <= '0;
      end else if (line_active) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  a_r1_fall_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_active) |-> $past(!any_ok));

  a_r2_rise_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_active) |-> $past(any_ok));

  a_r3_valid_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ok && line_active) |=> line_active);

endmodule

// File: rtl/lpm_power_seq.sv
module lpm_power_seq
  import line_pwr_pkg::*;
#(
  parameter int unsigned RAMP_CYC    = 200,
  parameter int unsigned HOLD_CYC    = 100,
  parameter bit          USE_HOLDOFF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_n,
  input  logic wake_force,
  input  logic line_active,
  output logic supply_en,
  output logic drv_en
);
  localparam int RW = $clog2(RAMP_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [RW-1:0] RAMP_LIM = RW'(RAMP_CYC - 1);

  pw_state_e     state, state_nx;
  logic [RW-1:0] ramp_cnt;
  logic          shut_q;
  logic          hold_active;
  logic          want_on;
  logic          ramp_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_q <= 1'b1;
    else        shut_q <= shut_n;
  end

  if (USE_HOLDOFF) begin : g_hold
    logic [HW-1:0] hold_cnt;
    logic          release_evt;
    assign release_evt = shut_n && !shut_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hold_cnt <= '0;
      else if (!shut_n)       hold_cnt <= '0;
      else if (release_evt)   hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
    end
    assign hold_active = release_evt || (hold_cnt != '0);
  end else begin : g_nohold
    assign hold_active = 1'b0;
  end

  assign want_on   = shut_n && (wake_force || hold_active || line_active);
  assign ramp_done = (state == PW_RAMP) && (ramp_cnt == RAMP_LIM);

  always_comb begin
    state_nx = state;
    case (state)
      PW_OFF:  if (want_on) state_nx = PW_RAMP;
      PW_RAMP: if (!want_on) state_nx = PW_OFF;
               else if (ramp_done) state_nx = PW_ON;
      PW_ON:   if (!want_on) state_nx = PW_OFF;
      default: state_nx = PW_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PW_OFF;
      ramp_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == PW_RAMP && state_nx == PW_RAMP) ramp_cnt <= ramp_cnt + 1'b1;
      else                                         ramp_cnt <= '0;
    end
  end

  assign supply_en = (state != PW_OFF);
  assign drv_en    = (state == PW_ON);

  a_r4_shutdown_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_n |=> (!supply_en && !drv_en));

  a_r5_force_up: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_n && wake_force) |=> supply_en);

  a_r6_auto_down: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_n && !wake_force && !hold_active && !line_active) |=> !supply_en);

  a_r7_supply_before_drv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(supply_en));

endmodule

// File: rtl/line_pwr_mgr.sv
module line_pwr_mgr
  import line_pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int          N_RX        = 2,
  parameter int unsigned IDLE_US     = 30,
  parameter int unsigned ACT_US      = 1,
  parameter int unsigned RAMP_US     = 100,
  parameter int unsigned HOLD_US     = 100_000,
  parameter bit          USE_HOLDOFF = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_RX-1:0] lvl_ok_async,
  input  logic            shut_n,
  input  logic            wake_force,
  input  logic            rcv_en_n,
  output logic            line_active,
  output logic            supply_en,
  output logic            drv_en,
  output logic            rcv_out_en
);
  localparam int unsigned IDLE_CYC = us_to_cyc(64'(IDLE_US), 64'(CLK_HZ));
  localparam int unsigned ACT_CYC  = us_to_cyc(64'(ACT_US),  64'(CLK_HZ));
  localparam int unsigned RAMP_CYC = us_to_cyc(64'(RAMP_US), 64'(CLK_HZ));
  localparam int unsigned HOLD_CYC = us_to_cyc(64'(HOLD_US), 64'(CLK_HZ));

  logic [N_RX-1:0] lvl_ok;

  lpm_sync #(.W(N_RX)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lvl_ok_async),
    .q     (lvl_ok)
  );

  lpm_line_detect #(
    .N_RX     (N_RX),
    .IDLE_CYC (IDLE_CYC),
    .ACT_CYC  (ACT_CYC)
  ) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_ok      (lvl_ok),
    .line_active (line_active)
  );

  lpm_power_seq #(
    .RAMP_CYC    (RAMP_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .USE_HOLDOFF (USE_HOLDOFF)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .shut_n      (shut_n),
    .wake_force  (wake_force),
    .line_active (line_active),
    .supply_en   (supply_en),
    .drv_en      (drv_en)
  );

  // Receiver outputs depend on their own enable only (R8).
  assign rcv_out_en = !rcv_en_n;

endmodule

// File: tb/sim_line_pwr_mgr.sv
`timescale 1ns/1ps
module sim_line_pwr_mgr;
  localparam int unsigned HZ   = 2_000_000;
  localparam int          NR   = 3;
  localparam int unsigned HUS  = 50;
  // Bench-side conversion: cycles = us * MHz
  localparam int IDLE = 30  * (HZ / 1_000_000);
  localparam int ACT  = 1   * (HZ / 1_000_000);
  localparam int RAMP = 100 * (HZ / 1_000_000);
  localparam int HOLD = HUS * (HZ / 1_000_000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] lvl = '0;
  logic shut_n = 1'b1;
  logic wake_force = 1'b0;
  logic rcv_en_n = 1'b0;
  logic line_active, supply_en, drv_en, rcv_out_en;

  int n_checks = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  line_pwr_mgr #(
    .CLK_HZ(HZ), .N_RX(NR), .IDLE_US(30), .ACT_US(1),
    .RAMP_US(100), .HOLD_US(HUS), .USE_HOLDOFF(1'b1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .lvl_ok_async(lvl), .shut_n(shut_n),
    .wake_force(wake_force), .rcv_en_n(rcv_en_n), .line_active(line_active),
    .supply_en(supply_en), .drv_en(drv_en), .rcv_out_en(rcv_out_en)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // which: 0 line_active, 1 supply_en, 2 drv_en
  function automatic logic pick(input int which);
    case (which)
      0: return line_active;
      1: return supply_en;
      default: return drv_en;
    endcase
  endfunction

  task automatic edges_until(input int which, input logic tgt, output int n);
    n = 0;
    while (pick(which) !== tgt && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int n;
    int seen;
    repeat (4) @(posedge clk);
    #1;
    check("R10 line_active after reset", line_active, 0);
    check("R10 supply_en after reset", supply_en, 0);
    check("R10 drv_en after reset", drv_en, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) step();
    check("R10 stays down with idle lines", supply_en, 0);

    // R1/R2/R6/R7: sweep every non-empty receiver pattern
    for (int pat = 1; pat < (1 << NR); pat++) begin
      @(negedge clk); lvl = NR'(pat);
      edges_until(0, 1'b1, n);
      check($sformatf("R2 rise latency pat %0d", pat), n, ACT + 2);
      step();
      check("R6 supply up after activity", supply_en, 1);
      check("R7 drivers wait for ramp", drv_en, 0);
      edges_until(2, 1'b1, n);
      check("R7 ramp length", n, RAMP);
      @(negedge clk); lvl = '0;
      edges_until(0, 1'b0, n);
      check($sformatf("R1 fall latency pat %0d", pat), n, IDLE + 2);
      step();
      check("R6 supply down after idle", supply_en, 0);
      check("R6 drivers down after idle", drv_en, 0);
    end

    // R3: burst one sample short is ignored, exact length qualifies
    @(negedge clk); lvl = 3'b001;
    repeat (ACT - 1) @(negedge clk);
    lvl = '0;
    seen = 0;
    for (int k = 0; k < 12; k++) begin step(); if (line_active) seen++; end
    check("R3 short burst ignored", seen, 0);
    @(negedge clk); lvl = 3'b100;
    repeat (ACT) @(negedge clk);
    lvl = '0;
    seen = 0;
    for (int k = 0; k < 4; k++) begin step(); if (line_active) seen++; end
    check("R3 exact-length burst qualifies", (seen > 0) ? 1 : 0, 1);
    // R3: a valid sample while active restarts the idle count
    edges_until(0, 1'b0, n);
    @(negedge clk); lvl = 3'b010;
    edges_until(0, 1'b1, n);
    @(negedge clk); lvl = '0;
    repeat (IDLE / 2) @(negedge clk);
    lvl = 3'b010;
    @(negedge clk); lvl = '0;
    edges_until(0, 1'b0, n);
    check("R3 idle count restarts after pulse", n, IDLE + 2);
    step();

    // R4/R11: manual shutdown overrides activity and keep-awake
    @(negedge clk); lvl = 3'b001;
    edges_until(2, 1'b1, n);
    check("R6 powered by activity", drv_en, 1);
    @(negedge clk); wake_force = 1'b1; shut_n = 1'b0;
    step();
    check("R4 supply off under shutdown", supply_en, 0);
    check("R4 drivers off under shutdown", drv_en, 0);
    check("R11 status held during shutdown", line_active, 1);
    @(negedge clk); lvl = '0;
    edges_until(0, 1'b0, n);
    check("R11 fall timed during shutdown", n, IDLE + 2);
    @(negedge clk); lvl = 3'b010;
    edges_until(0, 1'b1, n);
    check("R11 rise timed during shutdown", n, ACT + 2);
    check("R4 still off with activity and keep-awake", supply_en, 0);
    @(negedge clk); lvl = '0;
    edges_until(0, 1'b0, n);

    // R5: keep-awake holds the interface up with idle lines
    @(negedge clk); shut_n = 1'b1;
    step();
    check("R5 supply up under keep-awake", supply_en, 1);
    edges_until(2, 1'b1, n);
    check("R5/R7 ramp under keep-awake", n, RAMP);
    repeat (HOLD + 10) step();
    check("R5 stays up with idle lines", supply_en, 1);
    @(negedge clk); wake_force = 1'b0;
    step();
    check("R6 auto shutdown once keep-awake drops", supply_en, 0);

    // R9: hold-off after shutdown release
    @(negedge clk); shut_n = 1'b0;
    repeat (3) step();
    @(negedge clk); shut_n = 1'b1;
    step();
    check("R9 supply up on release", supply_en, 1);
    edges_until(1, 1'b0, n);
    check("R9 hold-off length", n + 1, HOLD + 2);
    check("R9 drivers not reached within hold", drv_en, 0);

    // R8: receiver outputs follow only their enable
    for (int v = 0; v < 2; v++) begin
      @(negedge clk); rcv_en_n = v[0]; #1;
      check("R8 follows enable while off", rcv_out_en, 1 - v);
    end
    @(negedge clk); wake_force = 1'b1; rcv_en_n = 1'b0;
    edges_until(2, 1'b1, n);
    for (int v = 1; v >= 0; v--) begin
      @(negedge clk); rcv_en_n = v[0]; #1;
      check("R8 follows enable while on", rcv_out_en, 1 - v);
    end
    @(negedge clk); shut_n = 1'b0;
    step();
    check("R8 unchanged by shutdown", rcv_out_en, 1);
    check("R4 shutdown from fully on", drv_en, 0);

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule